// File: doc/BRIEF.md
# Command/Response Serial Master

This block is a half-duplex serial master. Each frame it sends an 8-bit command word to an attached slave. One idle serial clock period follows, and then it collects a reply of programmable length, from 4 to 16 bits. Command words are queued in a small transmit FIFO. Completed replies are placed in a receive FIFO, right-aligned and zero-extended.

The block drives the serial clock, an active-low select and the outbound data line, and it samples the inbound data line. A programmable divider sets the serial clock to the system clock divided by an even value. The master changes outbound data on falling serial edges and samples inbound data on rising serial edges, most significant bit first in both directions.

The controller is a five-state machine:
- IDLE waits for a divider tick with a queued command and free receive space. It then goes to CMD.
- CMD shifts out eight command bits. On the eighth falling edge it goes to TURN.
- TURN runs one full clock with nothing sampled. On its falling edge it goes to RESP.
- RESP samples one reply bit per rising edge. On the last falling edge it goes to DONE.
- DONE pushes the reply into the receive FIFO and goes back to IDLE.

Top module: `cmd_resp_master`

## Requirements
- R1: After reset, sel_n is 1, sclk is 0, mosi is 0, tx_full is 0 and rx_empty is 1.
- R2: A frame sends the command popped from the transmit FIFO on mosi, most significant bit first. Each bit is valid at rising sclk edges 1 to 8 of the frame, and mosi changes only while sclk is low.
- R3: miso is ignored during the 8 command clocks and the following turnaround clock. Reply bits are sampled at rising sclk edges 10 to 9+N, and mosi is 0 outside the command phase.
- R4: resp_len sets the reply length N. A code of 3 to 15 gives N = code+1, and codes 0 to 2 give N = 4. The length is captured when the frame starts, and a frame has exactly 9+N rising sclk edges, which is 13 to 25.
- R5: sel_n is low for the whole frame and rises together with the last falling sclk edge. sclk is 0 whenever sel_n is 1.
- R6: The sclk period is 2*H system clocks, where H is half_div. A half_div of 0 acts as 1.
- R7: The reply is pushed into the receive FIFO as a 16-bit word. The first bit received becomes bit N-1, the last bit received becomes bit 0, and the bits above N-1 are zero.
- R8: A frame starts only when the transmit FIFO holds a command and the receive FIFO is not full. Queued commands wait, and are not lost, while the receive FIFO is full.
- R9: A push while tx_full is 1 is dropped, and a pop while rx_empty is 1 has no effect. Both FIFOs keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Write tx_data into the command FIFO |
| tx_data | input | 8 | Command word to queue |
| tx_full | output | 1 | Command FIFO is full |
| rx_pop | input | 1 | Remove the head of the reply FIFO |
| rx_data | output | 16 | Head of the reply FIFO (show-ahead) |
| rx_empty | output | 1 | Reply FIFO is empty |
| half_div | input | DIV_W | System clocks per sclk half period |
| resp_len | input | 4 | Reply length code |
| sclk | output | 1 | Serial clock, idle low |
| sel_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Outbound serial data |
| miso | input | 1 | Inbound serial data |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and DIV_W = 4. The shallow FIFOs let a handful of commands reach a full receive FIFO, which stalls frames, and a full transmit FIFO, which drops pushes. The 4-bit divider covers the whole half_div range from 0 to 15. This includes the zero case and slow frames that let pushes pile up. A bench slave drives random bits on miso outside the reply window and checks each captured command. It also checks the edge count of every frame and the sclk period.

// File: rtl/cmd_resp_pkg.sv
package cmd_resp_pkg;
    localparam int CMD_BITS  = 8;
    localparam int RESP_MAX  = 16;
    localparam int RESP_MIN  = 4;
    localparam int LEN_W     = $clog2(RESP_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TURN,
        ST_RESP,
        ST_DONE
    } frame_state_t;
endpackage

// File: rtl/sm_fifo.sv
module sm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [AW:0]      count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= rptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wdata;
        end
    end
endmodule

// File: rtl/sm_tick.sv
module sm_tick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (half_div == '0) ? '0 : half_div - 1'b1;
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sm_frame.sv
module sm_frame
    import cmd_resp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                tx_empty,
    input  logic [CMD_BITS-1:0] tx_word,
    input  logic                rx_full,
    input  logic [LEN_W-1:0]    resp_code,
    input  logic                miso,
    output logic                tx_pop,
    output logic                rx_push,
    output logic [RESP_MAX-1:0] rx_word,
    output logic                sclk,
    output logic                sel_n,
    output logic                mosi
);
    localparam logic [LEN_W-1:0] CMD_LAST = LEN_W'(CMD_BITS - 1);
    localparam logic [LEN_W-1:0] MIN_LAST = LEN_W'(RESP_MIN - 1);

    frame_state_t        state;
    frame_state_t        nxt;
    logic [LEN_W-1:0]    bit_cnt;
    logic [LEN_W-1:0]    resp_last;
    logic [CMD_BITS-2:0] cmd_rest;
    logic [RESP_MAX-1:0] rx_sh;
    logic                start;
    logic                rise;
    logic                fall;

    assign start   = tick && !tx_empty && !rx_full;
    assign rise    = tick && !sclk;
    assign fall    = tick && sclk;
    assign tx_pop  = (state == ST_IDLE) && start;
    assign rx_push = (state == ST_DONE);
    assign rx_word = rx_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_CMD;
            ST_CMD:  if (fall && bit_cnt == CMD_LAST) nxt = ST_TURN;
            ST_TURN: if (fall) nxt = ST_RESP;
            ST_RESP: if (fall && bit_cnt == resp_last) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs and shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk      <= 1'b0;
            sel_n     <= 1'b1;
            mosi      <= 1'b0;
            bit_cnt   <= '0;
            resp_last <= MIN_LAST;
            cmd_rest  <= '0;
            rx_sh     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk <= 1'b0;
                    if (start) begin
                        sel_n     <= 1'b0;
                        mosi      <= tx_word[CMD_BITS-1];
                        cmd_rest  <= tx_word[CMD_BITS-2:0];
                        bit_cnt   <= '0;
                        rx_sh     <= '0;
                        resp_last <= (resp_code < MIN_LAST) ? MIN_LAST : resp_code;
                    end
                end
                ST_CMD: begin
                    if (rise) begin
                        sclk <= 1'b1;
                    end else if (fall) begin
                        sclk <= 1'b0;
                        if (bit_cnt == CMD_LAST) begin
                            mosi    <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            mosi     <= cmd_rest[CMD_BITS-2];
                            cmd_rest <= {cmd_rest[CMD_BITS-3:0], 1'b0};
                            bit_cnt  <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_TURN: begin
                    if (rise) begin
                        sclk <= 1'b1;
                    end else if (fall) begin
                        sclk <= 1'b0;
                    end
                end
                ST_RESP: begin
                    if (rise) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[RESP_MAX-2:0], miso};
                    end else if (fall) begin
                        sclk <= 1'b0;
                        if (bit_cnt == resp_last) begin
                            sel_n <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    sel_n <= 1'b1;
                end
                default: begin
                    sel_n <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/cmd_resp_master.sv
module cmd_resp_master
    import cmd_resp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_push,
    input  logic [CMD_BITS-1:0] tx_data,
    output logic                tx_full,
    input  logic                rx_pop,
    output logic [RESP_MAX-1:0] rx_data,
    output logic                rx_empty,
    input  logic [DIV_W-1:0]    half_div,
    input  logic [LEN_W-1:0]    resp_len,
    output logic                sclk,
    output logic                sel_n,
    output logic                mosi,
    input  logic                miso
);
    logic                tick;
    logic                tx_empty_w;
    logic                rx_full_w;
    logic                tx_pop_w;
    logic                rx_push_w;
    logic [CMD_BITS-1:0] tx_head;
    logic [RESP_MAX-1:0] rx_word;

    sm_fifo #(.WIDTH(CMD_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(tx_data),
        .pop(tx_pop_w), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty_w)
    );

    sm_fifo #(.WIDTH(RESP_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push_w), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data),
        .full(rx_full_w), .empty(rx_empty)
    );

    sm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .half_div(half_div), .tick(tick)
    );

    sm_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tx_empty(tx_empty_w), .tx_word(tx_head),
        .rx_full(rx_full_w), .resp_code(resp_len), .miso(miso),
        .tx_pop(tx_pop_w), .rx_push(rx_push_w), .rx_word(rx_word),
        .sclk(sclk), .sel_n(sel_n), .mosi(mosi)
    );
endmodule

// File: rtl/cmd_resp_master_chk.sv
module cmd_resp_master_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sel_n,
    input logic mosi,
    input logic tx_empty,
    input logic rx_full,
    input logic rx_push
);
    logic       sclk_q;
    logic [5:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            if (sel_n) begin
                rise_cnt <= '0;
            end else if (sclk && !sclk_q) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R5
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !sclk);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sclk && $past(sclk)) |-> $stable(mosi));

    // R3
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !mosi);

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> $past(!tx_empty && !rx_full));

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (rise_cnt >= 6'd13 && rise_cnt <= 6'd25));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
endmodule

bind cmd_resp_master cmd_resp_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .mosi(mosi),
    .tx_empty(tx_empty_w), .rx_full(rx_full_w), .rx_push(rx_push_w)
);

// File: tb/sim_cmd_resp_master.sv
`timescale 1ns/1ps
module sim_cmd_resp_master;
    localparam int DEPTH = 4;
    localparam int DW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic        rx_empty;
    logic [DW-1:0] half_div = 4'd1;
    logic [3:0]  resp_len = 4'd3;
    logic        sclk, sel_n, mosi;
    logic        miso;

    int n_chk = 0;
    int n_err = 0;
    int frames = 0;
    int cur_n = 4;
    int cur_h = 1;
    bit finished = 0;
    logic [7:0]  exp_cmd[$];
    logic [15:0] exp_rx[$];

    always #2.5 clk = ~clk;

    cmd_resp_master #(.FIFO_DEPTH(DEPTH), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .half_div(half_div), .resp_len(resp_len),
        .sclk(sclk), .sel_n(sel_n), .mosi(mosi), .miso(miso)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] resp_fn(input logic [7:0] c);
        return {c ^ 8'h3C, {c[3:0], c[7:4]} + 8'd17};
    endfunction

    function automatic int n_of(input int code);
        return (code < 3) ? 4 : code + 1;
    endfunction

    function automatic logic [15:0] mask_of(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    // slave model, sampled away from the active edge
    logic        prev_sclk = 1'b0;
    logic        prev_sel = 1'b1;
    int          rises = 0;
    int          fn = 4;
    logic [7:0]  cap = '0;
    logic [15:0] val = '0;
    time         t_first = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            miso = 1'b0;
        end else begin
            if (prev_sel && !sel_n) begin
                rises = 0; cap = '0; fn = cur_n;
                miso = 1'($urandom() % 2);
                check(sclk == 1'b0, "R5 sclk low at select", int'(sclk), 0);
            end
            if (!sel_n && sclk && !prev_sclk) begin
                rises++;
                if (rises <= 8) cap = {cap[6:0], mosi};
                if (rises == 1) t_first = $time;
                if (rises == 2)
                    check(($time - t_first) == time'(10 * cur_h), "R6 sclk period",
                          int'($time - t_first), 10 * cur_h);
            end
            if (!sel_n && !sclk && prev_sclk) begin
                if (rises == 9) val = resp_fn(cap) & mask_of(fn);
                if (rises >= 9 && rises <= 8 + fn)
                    miso = val[fn - 1 - (rises - 9)];
                else
                    miso = 1'($urandom() % 2);
            end
            if (!prev_sel && sel_n) begin
                frames++;
                check(rises == 9 + fn, "R4 rising edges per frame", rises, 9 + fn);
                check(sclk == 1'b0, "R5 sclk low at frame end", int'(sclk), 0);
                if (exp_cmd.size() > 0) begin
                    check(cap == exp_cmd[0], "R2 command bits", int'(cap), int'(exp_cmd[0]));
                    void'(exp_cmd.pop_front());
                end else begin
                    check(1'b0, "R8 unexpected frame", frames, 0);
                end
                exp_rx.push_back(resp_fn(cap) & mask_of(fn));
            end
        end
        prev_sclk = sclk;
        prev_sel  = sel_n;
    end

    task automatic setup(input int h, input int code);
        @(negedge clk);
        half_div = DW'(h);
        resp_len = 4'(code);
        cur_h = (h == 0) ? 1 : h;
        cur_n = n_of(code);
    endtask

    task automatic push_now(input logic [7:0] c, output bit acc);
        @(negedge clk);
        tx_push = 1'b1;
        tx_data = c;
        acc = !tx_full;
        if (acc) exp_cmd.push_back(c);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_wait(input logic [7:0] c);
        bit acc;
        while (tx_full) @(negedge clk);
        push_now(c, acc);
    endtask

    task automatic drain(input int want);
        int got = 0;
        int guard = 0;
        while (got < want && guard < 20000) begin
            @(negedge clk);
            rx_pop = 1'b0;
            if (!rx_empty && exp_rx.size() > 0) begin
                check(rx_data == exp_rx[0], "R7 R3 reply word", int'(rx_data), int'(exp_rx[0]));
                void'(exp_rx.pop_front());
                rx_pop = 1'b1;
                got++;
            end
            guard++;
        end
        @(negedge clk);
        rx_pop = 1'b0;
        check(got == want, "R9 reply count", got, want);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit acc;
        int accepted;
        int f0;
        void'($urandom(32'd11));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(sel_n == 1'b1, "R1 sel_n", int'(sel_n), 1);
        check(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        check(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
        check(tx_full == 1'b0, "R1 tx_full", int'(tx_full), 0);
        check(rx_empty == 1'b1, "R1 rx_empty", int'(rx_empty), 1);

        // R9: pop on empty has no effect
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
        @(negedge clk);
        check(rx_empty == 1'b1, "R9 pop on empty", int'(rx_empty), 1);

        // directed lengths and dividers (R4, R6)
        setup(1, 3);  push_wait(8'hA5); drain(1);
        setup(2, 15); push_wait(8'h00); push_wait(8'hFF); drain(2);
        setup(3, 0);  push_wait(8'h3C); drain(1);
        setup(0, 8);  push_wait(8'h81); drain(1);

        // R8: receive FIFO full stalls frames
        setup(1, 7);
        f0 = frames;
        for (int i = 0; i < 6; i++) push_wait(8'(8'h10 + i));
        repeat (2000) @(negedge clk);
        check(frames - f0 == DEPTH, "R8 frames while rx full", frames - f0, DEPTH);
        check(sel_n == 1'b1, "R8 idle while rx full", int'(sel_n), 1);
        drain(6);

        // R9: pushes while full are dropped
        setup(15, 15);
        accepted = 0;
        f0 = frames;
        for (int i = 0; i < 7; i++) begin
            push_now(8'(8'hC0 + i), acc);
            if (acc) accepted++;
        end
        check(accepted < 7 && accepted >= DEPTH, "R9 pushes accepted", accepted, DEPTH + 1);
        drain(accepted);
        repeat (200) @(negedge clk);
        check(frames - f0 == accepted, "R9 frames after drops", frames - f0, accepted);
        check(rx_empty == 1'b1, "R9 nothing extra", int'(rx_empty), 1);

        // constrained random mix
        for (int b = 0; b < 12; b++) begin
            int k;
            setup(int'($urandom() % 4) + 1, int'($urandom() % 16));
            k = int'($urandom() % 4) + 1;
            for (int j = 0; j < k; j++) push_wait(8'($urandom()));
            drain(k);
        end

        repeat (50) @(negedge clk);
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule